// File: doc/BRIEF.md
# Weighted Round-Robin DMA Bus Arbiter

This block shares one host bus between a receive DMA requester and a transmit DMA requester. Each requester raises a request and is given the bus through its own grant line, one burst at a time. A single transfer-done pulse from the bus side closes the current burst. Arbitration happens only when the bus is idle or when that pulse arrives. The grant for the next burst is registered on the same clock edge, so a busy bus moves from one burst to the next with no dead cycle.

A five-bit configuration register controls the sharing. Each side has a two-bit weight code, and code n lets that side hold the bus for up to 2^n back-to-back bursts per turn. The weight is captured when the side's turn begins. A side that drops its request, or uses up its credit while the other side is waiting, hands the turn over. A lone requester is served indefinitely, and its credit is refilled each time it starts a fresh turn. A mode bit replaces the rotation with strict priority for receive. The register clears to zero on reset, which selects equal single-burst weights with rotation enabled.

Top module: `wrr_dma_arb`

## Requirements
- R1: At most one grant is high in any cycle, and a grant rises only for a side whose request was high in the cycle before.
- R2: Once a grant is high it stays high until a cycle with `xfer_done` high. A `xfer_done` pulse while no grant is high changes nothing.
- R3: Configuration bits [1:0] hold the receive weight code and bits [3:2] hold the transmit weight code. Code n (0..3) lets a side take up to 2^n consecutive bursts per turn while the other side is requesting.
- R4: With rotation enabled, the turn passes to the other side when the current side has used its credit and the other side is requesting. After reset the first turn belongs to receive.
- R5: When configuration bit [4] is 1, every arbitration grants receive if it is requesting, and otherwise grants transmit.
- R6: Reset clears the configuration register to 0 and drops both grants.
- R7: A side that requests alone is granted at every arbitration, whatever its remaining credit. Its credit refills to its current weight whenever it starts a new turn.
- R8: If the side holding the turn is not requesting at an arbitration and the other side is, the other side is granted with fresh credit.
- R9: A weight written during a turn does not change that turn's credit. It takes effect at the next turn that side starts.
- R10: While requests persist and `xfer_done` is held high, a new burst is granted on every clock, with the next grant visible the cycle after each done.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration value: [1:0] receive weight, [3:2] transmit weight, [4] rotation off |
| rx_req | input | 1 | Receive DMA request |
| tx_req | input | 1 | Transmit DMA request |
| xfer_done | input | 1 | End of the currently granted burst |
| rx_gnt | output | 1 | Bus granted to receive DMA |
| tx_gnt | output | 1 | Bus granted to transmit DMA |

## Verification
The bench goes after the weight decode with asymmetric weights in both directions. A design with swapped weight fields, or with a linear rather than power-of-two credit, would produce the wrong run lengths in the grant sequence. It rewrites the weights in the middle of a long turn. A design that did not capture the limit at turn start would cut the turn short. It drops a request mid-turn, feeds a lone requester far past its credit, and pulses done while idle; a design wrong here would either stall or grant a silent side. It also lets receive arrive while transmit holds the bus in priority mode, where a design that ignored the mode bit would keep serving transmit.

// File: rtl/wrr_arb_pkg.sv
package wrr_arb_pkg;
  typedef enum logic {
    SIDE_RX = 1'b0,
    SIDE_TX = 1'b1
  } side_e;
endpackage

// File: rtl/wrr_cfg_reg.sv
module wrr_cfg_reg #(
  parameter int unsigned WT_W = 2,
  localparam int unsigned CFG_W = 2 * WT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [WT_W-1:0]  rx_wt,
  output logic [WT_W-1:0]  tx_wt,
  output logic             rr_off
);
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign rx_wt  = cfg_q[WT_W-1:0];
  assign tx_wt  = cfg_q[2*WT_W-1:WT_W];
  assign rr_off = cfg_q[2*WT_W];
endmodule

// File: rtl/wrr_credit_ctr.sv
module wrr_credit_ctr
  import wrr_arb_pkg::*;
#(
  parameter int unsigned WT_W = 2,
  localparam int unsigned CNT_W = 1 << WT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WT_W-1:0] rx_wt,
  input  logic [WT_W-1:0] tx_wt,
  input  logic            clr,
  input  logic            start,
  input  side_e           start_side,
  input  logic            adv,
  output side_e           turn,
  output logic            has_credit
);
  logic [1:0][WT_W-1:0]  wts;
  logic [1:0][CNT_W-1:0] lim_of;
  side_e                 turn_q, turn_d;
  logic [CNT_W-1:0]      used_q, used_d;
  logic [CNT_W-1:0]      lim_q, lim_d;

  assign wts = {tx_wt, rx_wt};

  for (genvar s = 0; s < 2; s++) begin : g_lim
    assign lim_of[s] = CNT_W'(1) << wts[s];
  end

  always_comb begin
    turn_d = turn_q;
    used_d = used_q;
    lim_d  = lim_q;
    if (clr) begin
      used_d = '0;
    end else if (start) begin
      turn_d = start_side;
      used_d = CNT_W'(1);
      lim_d  = lim_of[start_side];
    end else if (adv) begin
      if (used_q == '0) begin
        used_d = CNT_W'(1);
        lim_d  = lim_of[turn_q];
      end else begin
        used_d = used_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      turn_q <= SIDE_RX;
      used_q <= '0;
      lim_q  <= CNT_W'(1);
    end else begin
      turn_q <= turn_d;
      used_q <= used_d;
      lim_q  <= lim_d;
    end
  end

  assign turn       = turn_q;
  assign has_credit = (used_q == '0) || (used_q < lim_q);
endmodule

// File: rtl/wrr_grant_ctl.sv
module wrr_grant_ctl
  import wrr_arb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rx_req,
  input  logic  tx_req,
  input  logic  xfer_done,
  input  logic  rr_off,
  input  side_e turn,
  input  logic  has_credit,
  output logic  rx_gnt,
  output logic  tx_gnt,
  output logic  clr,
  output logic  start,
  output side_e start_side,
  output logic  adv
);
  logic [1:0] req;
  logic       busy, arb_pt;
  logic       pick_any;
  side_e      pick_side, other;
  logic       rx_gnt_q, tx_gnt_q, rx_gnt_d, tx_gnt_d;

  assign req    = {tx_req, rx_req};
  assign busy   = rx_gnt_q | tx_gnt_q;
  assign arb_pt = !busy || xfer_done;
  assign other  = side_e'(~turn);

  always_comb begin
    pick_any   = 1'b0;
    pick_side  = SIDE_RX;
    clr        = 1'b0;
    start      = 1'b0;
    start_side = SIDE_RX;
    adv        = 1'b0;
    if (arb_pt) begin
      if (rr_off) begin
        clr = 1'b1;
        if (rx_req) begin
          pick_any  = 1'b1;
          pick_side = SIDE_RX;
        end else if (tx_req) begin
          pick_any  = 1'b1;
          pick_side = SIDE_TX;
        end
      end else if (req[turn] && has_credit) begin
        pick_any  = 1'b1;
        pick_side = turn;
        adv       = 1'b1;
      end else if (req[other]) begin
        pick_any   = 1'b1;
        pick_side  = other;
        start      = 1'b1;
        start_side = other;
      end else if (req[turn]) begin
        pick_any   = 1'b1;
        pick_side  = turn;
        start      = 1'b1;
        start_side = turn;
      end
    end
  end

  always_comb begin
    rx_gnt_d = rx_gnt_q;
    tx_gnt_d = tx_gnt_q;
    if (arb_pt) begin
      rx_gnt_d = pick_any && (pick_side == SIDE_RX);
      tx_gnt_d = pick_any && (pick_side == SIDE_TX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_gnt_q <= 1'b0;
      tx_gnt_q <= 1'b0;
    end else begin
      rx_gnt_q <= rx_gnt_d;
      tx_gnt_q <= tx_gnt_d;
    end
  end

  assign rx_gnt = rx_gnt_q;
  assign tx_gnt = tx_gnt_q;
endmodule

// File: rtl/wrr_dma_arb.sv
module wrr_dma_arb
  import wrr_arb_pkg::*;
#(
  parameter int unsigned WT_W = 2,
  localparam int unsigned CFG_W = 2 * WT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             rx_req,
  input  logic             tx_req,
  input  logic             xfer_done,
  output logic             rx_gnt,
  output logic             tx_gnt
);
  logic [WT_W-1:0] rx_wt, tx_wt;
  logic            rr_off;
  logic            clr, start, adv, has_credit;
  side_e           start_side, turn;

  wrr_cfg_reg #(.WT_W(WT_W)) cfg_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rx_wt (rx_wt),
    .tx_wt (tx_wt),
    .rr_off(rr_off)
  );

  wrr_credit_ctr #(.WT_W(WT_W)) crd_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_wt     (rx_wt),
    .tx_wt     (tx_wt),
    .clr       (clr),
    .start     (start),
    .start_side(start_side),
    .adv       (adv),
    .turn      (turn),
    .has_credit(has_credit)
  );

  wrr_grant_ctl gnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_req    (rx_req),
    .tx_req    (tx_req),
    .xfer_done (xfer_done),
    .rr_off    (rr_off),
    .turn      (turn),
    .has_credit(has_credit),
    .rx_gnt    (rx_gnt),
    .tx_gnt    (tx_gnt),
    .clr       (clr),
    .start     (start),
    .start_side(start_side),
    .adv       (adv)
  );
endmodule

// File: rtl/wrr_dma_arb_chk.sv
module wrr_dma_arb_chk #(
  parameter int unsigned WT_W = 2,
  localparam int unsigned MAX_RUN = 1 << ((1 << WT_W) - 1)
) (
  input logic clk,
  input logic rst_n,
  input logic rx_req,
  input logic tx_req,
  input logic xfer_done,
  input logic rr_off,
  input logic rx_gnt,
  input logic tx_gnt
);
  logic [7:0] rx_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          rx_run_q <= '0;
    else if (!tx_req || tx_gnt || rr_off) rx_run_q <= '0;
    else if (rx_gnt && xfer_done)         rx_run_q <= rx_run_q + 8'd1;
  end

  // R1
  gnt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_gnt && tx_gnt));

  // R1
  rx_gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_gnt) |-> $past(rx_req));

  // R2
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_gnt && !xfer_done) |=> rx_gnt);

  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_gnt && !xfer_done) |=> tx_gnt);

  // R5
  fixed_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_off && rx_req && ((!rx_gnt && !tx_gnt) || xfer_done)) |=> rx_gnt);

  // R3
  credit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_run_q <= 8'(MAX_RUN));
endmodule

bind wrr_dma_arb wrr_dma_arb_chk #(.WT_W(WT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_req   (rx_req),
  .tx_req   (tx_req),
  .xfer_done(xfer_done),
  .rr_off   (rr_off),
  .rx_gnt   (rx_gnt),
  .tx_gnt   (tx_gnt)
);

// File: tb/wrr_dma_arb_tb_top.sv
module wrr_dma_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {cfg[26:22], rx_req[21], tx_req[20], tag[19:16], expected[15:0]}
  // expected: MSB is the first burst, 1 = receive granted, 0 = transmit
  localparam logic [26:0] VEC [NVEC] = '{
    {5'b00000, 1'b1, 1'b1, 4'd4, 16'hAAAA},
    {5'b00001, 1'b1, 1'b1, 4'd3, 16'hDB6D},
    {5'b01100, 1'b1, 1'b1, 4'd3, 16'h8040},
    {5'b00111, 1'b1, 1'b1, 4'd3, 16'hFF3F},
    {5'b00100, 1'b1, 1'b1, 4'd3, 16'h9249},
    {5'b10011, 1'b1, 1'b1, 4'd5, 16'hFFFF},
    {5'b00000, 1'b0, 1'b1, 4'd7, 16'h0000},
    {5'b01111, 1'b1, 1'b0, 4'd7, 16'hFFFF}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [4:0] cfg_wdata;
  logic       rx_req, tx_req, xfer_done;
  logic       rx_gnt, tx_gnt;
  int         total = 0;
  int         bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrr_dma_arb dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .rx_req   (rx_req),
    .tx_req   (tx_req),
    .xfer_done(xfer_done),
    .rx_gnt   (rx_gnt),
    .tx_gnt   (tx_gnt)
  );

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic er, input logic et);
    total++;
    if (rx_gnt !== er || tx_gnt !== et) begin
      bad++;
      $display("FAIL %s: rx_gnt/tx_gnt actual=%b%b expected=%b%b at %0t",
               tag, rx_gnt, tx_gnt, er, et, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    rx_req = 1'b0; tx_req = 1'b0; xfer_done = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [4:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R6: reset state, no grants
    do_reset();
    chk("R6", 1'b0, 1'b0);

    // R6 R4 R10: default config alternates single bursts, receive first
    rx_req = 1'b1; tx_req = 1'b1; xfer_done = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R6", (i % 2) == 0, (i % 2) != 0);
    end

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      wr_cfg(VEC[v][26:22]);
      rx_req = VEC[v][21]; tx_req = VEC[v][20]; xfer_done = 1'b1;
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        chk(tag_name(VEC[v][19:16]), VEC[v][15-b], !VEC[v][15-b]);
      end
    end

    // R2: done while idle has no effect
    do_reset();
    xfer_done = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", 1'b0, 1'b0);
    // R2: grant holds without done even after request drops
    xfer_done = 1'b0; rx_req = 1'b1;
    @(negedge clk);
    chk("R2", 1'b1, 1'b0);
    rx_req = 1'b0; tx_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", 1'b1, 1'b0);
    xfer_done = 1'b1;
    @(negedge clk);
    chk("R1", 1'b0, 1'b1);
    tx_req = 1'b0;
    @(negedge clk);
    xfer_done = 1'b0;
    @(negedge clk);
    chk("R1", 1'b0, 1'b0);

    // R9: weight change mid-turn
    do_reset();
    wr_cfg(5'b00011);
    rx_req = 1'b1; tx_req = 1'b1; xfer_done = 1'b1;
    for (int b = 0; b < 11; b++) begin
      @(negedge clk);
      if (b < 8)       chk("R9", 1'b1, 1'b0);
      else if (b == 9) chk("R9", 1'b1, 1'b0);
      else             chk("R9", 1'b0, 1'b1);
      if (b == 1) begin cfg_we = 1'b1; cfg_wdata = 5'b00000; end
      else cfg_we = 1'b0;
    end

    // R8: dropping the request passes the turn
    do_reset();
    wr_cfg(5'b00011);
    rx_req = 1'b1; tx_req = 1'b1; xfer_done = 1'b1;
    @(negedge clk); chk("R8", 1'b1, 1'b0);
    @(negedge clk); chk("R8", 1'b1, 1'b0);
    rx_req = 1'b0;
    @(negedge clk); chk("R8", 1'b0, 1'b1);
    rx_req = 1'b1;
    @(negedge clk); chk("R8", 1'b1, 1'b0);
    @(negedge clk); chk("R8", 1'b1, 1'b0);

    // R5: receive preempts transmit at the next boundary
    do_reset();
    wr_cfg(5'b10000);
    tx_req = 1'b1; xfer_done = 1'b1;
    @(negedge clk); chk("R5", 1'b0, 1'b1);
    rx_req = 1'b1;
    @(negedge clk); chk("R5", 1'b1, 1'b0);
    @(negedge clk); chk("R5", 1'b1, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule